// File: doc/BRIEF.md
# Single-Wire Slave Wake and Sleep Sequencer

This block governs the power states of a slave device on a single-wire bus. The device starts asleep. In that state it watches a filtered copy of the bus for a low pulse long enough to be a wake request. When one arrives, the block waits a fixed power-up delay. It then reads the device's default configuration bytes (bus address, bus speed, trim) from a one-time-programmable memory through a valid/ready read port. Next it pulls the bus low for a ready pulse, and after that it enters the awake state. The block does not wait for the host to release the bus before any of these steps, so a long host pulse and the ready pulse can overlap on the wire.

While awake, the filtered bus level goes to the bit decoder on `bus_rx`. An inactivity timer sends the device back to sleep after a quiet period, whatever level the bus rests at. A control bit can turn the timer off. Power-on reset sets that bit, and so does a soft-reset strobe. All delays are counted in cycles of the slow time-base clock. The counts are parameters, and the ready pulse length is derived from the bit time.

The memory read port carries back-pressure on the request side only. The block raises `mem_req_valid` with an address and holds both steady until `mem_req_ready` is seen high at a clock edge. After that it issues nothing more until a response arrives. It accepts a byte in any cycle where `mem_rsp_valid` is high while a response is outstanding, and it has no way to stall the response. Responses at other times are ignored.

Top module: `wake_seq`

## Requirements
- R1: After reset the block is asleep (`st_asleep`=1, `st_waking`=0, `st_awake`=0), `bus_pd_en`=0, `aslp_en`=1, `cfg_bytes`=0, `mem_req_valid`=0 and `bus_rx`=1.
- R2: A change of bus level is accepted only after DEGLITCH_CYC consecutive synchronized samples at the new level. A low pulse of DEGLITCH_CYC-1 cycles does not wake a sleeping device and does not change `bus_rx` while awake.
- R3: Only a falling edge of the filtered level wakes the device. A bus that is already low when sleep begins, or a rising edge, leaves it asleep.
- R4: After the accepted falling edge the block spends PWRUP_CYC cycles in power-up and then starts initialization, whether or not the bus is still low. `st_waking` is 1 through power-up and initialization.
- R5: Initialization reads NUM_CFG bytes from addresses CFG_BASE, CFG_BASE+1, … in increasing order, one request at a time, under the port rules above. Byte i is placed in `cfg_bytes[8i+7:8i]`.
- R6: After the last byte the block holds `bus_pd_en`=1 for exactly READY_CYC = round(BIT_CYC×1.391) cycles and then becomes awake. This holds even when the host still drives the bus low.
- R7: While awake, `bus_rx` follows the filtered bus level, and a low pulse longer than the filter is passed on without starting a new wake sequence. Outside the awake state `bus_rx` is 1.
- R8: While awake with `aslp_en`=1, the block returns to sleep IDLE_CYC to IDLE_CYC+1 cycles after the last filtered bus edge or after entering the awake state. This applies with the bus idle high or idle low, and every filtered edge restarts the count.
- R9: A write strobe `aslp_wr_en` loads `aslp_wr_val` into `aslp_en`. With `aslp_en`=0 the block never leaves the awake state on its own. `soft_rst` sets `aslp_en` to 1 and restarts the inactivity count.
- R10: Exactly one of `st_asleep`, `st_waking`, `bus_pd_en`, `st_awake` is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_in | input | 1 | Raw bus level, asynchronous |
| bus_pd_en | output | 1 | Enables the bus pull-down (ready pulse) |
| bus_rx | output | 1 | Filtered bus level to the bit decoder, 1 unless awake |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Memory read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 8 | Read data byte |
| cfg_bytes | output | 8*NUM_CFG | Loaded configuration bytes |
| aslp_wr_en | input | 1 | Write strobe for the auto-sleep enable |
| aslp_wr_val | input | 1 | Value written to the auto-sleep enable |
| soft_rst | input | 1 | Soft-reset strobe |
| aslp_en | output | 1 | Current auto-sleep enable |
| st_asleep | output | 1 | Asleep flag |
| st_waking | output | 1 | Power-up or initialization in progress |
| st_awake | output | 1 | Awake flag |

## Verification
The wake path is tried with pulses one cycle under the filter length and pulses just over it. This separates filter rejection from acceptance. A short host break is compared with a break held past the start of the ready pulse, which shows that the sequence and the ready width do not depend on when the host releases the bus. Timeouts are run with the bus idle high, with it idle low, after mid-awake traffic and after a soft reset. These runs tell edge-restart, level-independence and the enable bit apart. The memory model alternates its ready signal, so a request stalled under back-pressure and the address order are both observed.

// File: rtl/wake_seq_pkg.sv
package wake_seq_pkg;

  typedef enum logic [2:0] {
    WK_SLEEP = 3'd0,
    WK_PWRUP = 3'd1,
    WK_INIT  = 3'd2,
    WK_READY = 3'd3,
    WK_AWAKE = 3'd4
  } wk_state_e;

  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_REQ  = 2'd1,
    LD_WAIT = 2'd2
  } ld_phase_e;

  // bit time scaled by 1.391, rounded to nearest
  function automatic int ready_cycles(input int bit_cyc);
    return (bit_cyc * 1391 + 500) / 1000;
  endfunction

endpackage

// File: rtl/wk_deglitch.sv
module wk_deglitch #(
  parameter int STABLE_CYC  = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic lvl,
  output logic rise,
  output logic fall
);
  localparam int CW = $clog2(STABLE_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   s;
  logic [CW-1:0]          cnt;
  logic                   flip;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign s    = sync_q[SYNC_STAGES-1];
  assign flip = (s != lvl) && (cnt == CW'(STABLE_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl  <= 1'b0;
      cnt  <= '0;
      rise <= 1'b0;
      fall <= 1'b0;
    end else begin
      rise <= flip & s;
      fall <= flip & ~s;
      if (s == lvl) begin
        cnt <= '0;
      end else if (flip) begin
        lvl <= s;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2: the filtered level only moves to a value the synchronizer already held
  a_r2_level_follows_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl != $past(lvl)) |-> ($past(s) == lvl));

  // R2: an edge pulse appears only together with a level change
  a_r2_edge_matches_level: assert property (@(posedge clk) disable iff (!rst_n)
    (rise || fall) |-> (lvl != $past(lvl)));

endmodule

// File: rtl/wk_idle_timer.sv
module wk_idle_timer #(
  parameter int LIMIT = 532500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic enable,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || restart) begin
      cnt <= '0;
    end else if (cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expire = run && enable && !restart && (cnt == LAST);

  // R8: a timeout never follows directly on a restart (LIMIT is at least 2)
  a_r8_expire_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> !$past(restart));

endmodule

// File: rtl/wk_cfg_loader.sv
module wk_cfg_loader
  import wake_seq_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int NUM_CFG  = 2,
  parameter int CFG_BASE = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic [ADDR_W-1:0]    req_addr,
  input  logic                 rsp_valid,
  input  logic [7:0]           rsp_data,
  output logic [8*NUM_CFG-1:0] cfg,
  output logic                 done
);
  localparam int IW = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1;
  localparam logic [IW-1:0] IDX_LAST = IW'(NUM_CFG - 1);

  ld_phase_e     phase;
  logic [IW-1:0] idx;
  logic          take;
  logic [7:0]    cfg_q [NUM_CFG];

  assign take      = (phase == LD_WAIT) && rsp_valid;
  assign req_valid = (phase == LD_REQ);
  assign req_addr  = ADDR_W'(CFG_BASE) + ADDR_W'(idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= LD_IDLE;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        LD_IDLE: if (start) begin
          phase <= LD_REQ;
          idx   <= '0;
        end
        LD_REQ: if (req_ready) phase <= LD_WAIT;
        LD_WAIT: if (rsp_valid) begin
          if (idx == IDX_LAST) begin
            phase <= LD_IDLE;
            done  <= 1'b1;
          end else begin
            idx   <= idx + 1'b1;
            phase <= LD_REQ;
          end
        end
        default: phase <= LD_IDLE;
      endcase
    end
  end

  generate
    for (genvar g = 0; g < NUM_CFG; g++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         cfg_q[g] <= 8'h00;
        else if (take && idx == IW'(g))     cfg_q[g] <= rsp_data;
      end
      assign cfg[8*g +: 8] = cfg_q[g];
    end
  endgenerate

  // R5: a stalled request keeps its address until accepted
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  // R5: completion only follows an accepted response
  a_r5_done_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rsp_valid));

  // R5: no new request in the cycle after a request was accepted
  a_r5_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);

endmodule

// File: rtl/wake_seq.sv
module wake_seq
  import wake_seq_pkg::*;
#(
  parameter int DEGLITCH_CYC = 11,
  parameter int PWRUP_CYC    = 11,
  parameter int BIT_CYC      = 23,
  parameter int IDLE_CYC     = 532500,
  parameter int ADDR_W       = 4,
  parameter int NUM_CFG      = 2,
  parameter int CFG_BASE     = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_in,
  output logic                 bus_pd_en,
  output logic                 bus_rx,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [ADDR_W-1:0]    mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [7:0]           mem_rsp_data,
  output logic [8*NUM_CFG-1:0] cfg_bytes,
  input  logic                 aslp_wr_en,
  input  logic                 aslp_wr_val,
  input  logic                 soft_rst,
  output logic                 aslp_en,
  output logic                 st_asleep,
  output logic                 st_waking,
  output logic                 st_awake
);
  localparam int READY_CYC = ready_cycles(BIT_CYC);
  localparam int SEQ_MAX   = (PWRUP_CYC > READY_CYC) ? PWRUP_CYC : READY_CYC;
  localparam int SW        = $clog2(SEQ_MAX + 1);

  wk_state_e   state;
  logic [SW-1:0] seq_cnt;
  logic        ld_start, ld_done;
  logic        dg_lvl, dg_rise, dg_fall;
  logic        idle_exp;
  logic        aslp_q;

  wk_deglitch #(
    .STABLE_CYC (DEGLITCH_CYC),
    .SYNC_STAGES(2)
  ) i_deglitch (
    .clk (clk),
    .rst_n(rst_n),
    .raw (bus_in),
    .lvl (dg_lvl),
    .rise(dg_rise),
    .fall(dg_fall)
  );

  wk_cfg_loader #(
    .ADDR_W  (ADDR_W),
    .NUM_CFG (NUM_CFG),
    .CFG_BASE(CFG_BASE)
  ) i_loader (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (ld_start),
    .req_valid(mem_req_valid),
    .req_ready(mem_req_ready),
    .req_addr (mem_req_addr),
    .rsp_valid(mem_rsp_valid),
    .rsp_data (mem_rsp_data),
    .cfg      (cfg_bytes),
    .done     (ld_done)
  );

  wk_idle_timer #(
    .LIMIT(IDLE_CYC)
  ) i_idle (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (state == WK_AWAKE),
    .restart(dg_rise | dg_fall | soft_rst),
    .enable (aslp_q),
    .expire (idle_exp)
  );

  // power-state sequence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= WK_SLEEP;
      seq_cnt  <= '0;
      ld_start <= 1'b0;
    end else begin
      ld_start <= 1'b0;
      case (state)
        WK_SLEEP: if (dg_fall) begin
          state   <= WK_PWRUP;
          seq_cnt <= '0;
        end
        WK_PWRUP: if (seq_cnt == SW'(PWRUP_CYC - 1)) begin
          state    <= WK_INIT;
          ld_start <= 1'b1;
          seq_cnt  <= '0;
        end else begin
          seq_cnt <= seq_cnt + 1'b1;
        end
        WK_INIT: if (ld_done) begin
          state   <= WK_READY;
          seq_cnt <= '0;
        end
        WK_READY: if (seq_cnt == SW'(READY_CYC - 1)) begin
          state   <= WK_AWAKE;
          seq_cnt <= '0;
        end else begin
          seq_cnt <= seq_cnt + 1'b1;
        end
        WK_AWAKE: if (idle_exp) state <= WK_SLEEP;
        default:  state <= WK_SLEEP;
      endcase
    end
  end

  // auto-sleep enable bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          aslp_q <= 1'b1;
    else if (soft_rst)   aslp_q <= 1'b1;
    else if (aslp_wr_en) aslp_q <= aslp_wr_val;
  end

  assign aslp_en   = aslp_q;
  assign bus_pd_en = (state == WK_READY);
  assign st_asleep = (state == WK_SLEEP);
  assign st_waking = (state == WK_PWRUP) || (state == WK_INIT);
  assign st_awake  = (state == WK_AWAKE);
  assign bus_rx    = st_awake ? dg_lvl : 1'b1;

  // ready-pulse width checker
  logic [SW:0] pd_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pd_run <= '0;
    else if (bus_pd_en) pd_run <= pd_run + 1'b1;
    else                pd_run <= '0;
  end

  // R6: every ready pulse is exactly READY_CYC cycles long
  a_r6_ready_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_pd_en) |-> (pd_run == (SW+1)'(READY_CYC)));

  // R3: leaving sleep needs a filtered falling edge
  a_r3_wake_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == WK_SLEEP && state != WK_SLEEP) |-> $past(dg_fall));

  // R9: with the enable cleared the awake state is kept
  a_r9_hold_awake: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WK_AWAKE && !aslp_q) |=> (state != WK_SLEEP));

  // R10: state flags are mutually exclusive and complete
  a_r10_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({st_asleep, st_waking, bus_pd_en, st_awake}));

  // R4: initialization is entered only from power-up
  a_r4_init_after_pwrup: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(state == WK_INIT)) |-> ($past(state) == WK_PWRUP));

endmodule

// File: tb/test_wake_seq.sv
module test_wake_seq;
  localparam int DG   = 4;
  localparam int PW   = 6;
  localparam int BIT  = 10;
  localparam int IDLE = 60;
  localparam int AW   = 4;
  localparam int NCFG = 2;
  localparam int BASE = 3;
  localparam int READY_EXP = 14; // round(10 * 1.391)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_drv = 1'b1;
  logic bus_in, bus_pd_en, bus_rx;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [7:0] mem_rsp_data = 8'h00;
  logic [8*NCFG-1:0] cfg_bytes;
  logic aslp_wr_en = 1'b0, aslp_wr_val = 1'b0, soft_rst = 1'b0;
  logic aslp_en, st_asleep, st_waking, st_awake;

  int vecs = 0;
  int errs = 0;
  bit done_flag = 1'b0;

  logic [AW-1:0] log_addr [8];
  int nlog = 0;
  bit pend = 1'b0;
  logic [AW-1:0] pend_addr = '0;

  always #10 clk = ~clk;

  assign bus_in = host_drv & ~bus_pd_en;

  wake_seq #(
    .DEGLITCH_CYC(DG), .PWRUP_CYC(PW), .BIT_CYC(BIT), .IDLE_CYC(IDLE),
    .ADDR_W(AW), .NUM_CFG(NCFG), .CFG_BASE(BASE)
  ) i_wake_seq (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_pd_en(bus_pd_en),
    .bus_rx(bus_rx), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .cfg_bytes(cfg_bytes), .aslp_wr_en(aslp_wr_en),
    .aslp_wr_val(aslp_wr_val), .soft_rst(soft_rst), .aslp_en(aslp_en),
    .st_asleep(st_asleep), .st_waking(st_waking), .st_awake(st_awake)
  );

  function automatic logic [7:0] mem_val(input logic [AW-1:0] a);
    return 8'h5A ^ {a, a};
  endfunction

  // memory model: ready alternates, response one cycle after acceptance
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = pend;
      mem_rsp_data  = pend ? mem_val(pend_addr) : 8'h00;
      pend = 1'b0;
      mem_req_ready = ~mem_req_ready;
      if (mem_req_valid && mem_req_ready) begin
        pend = 1'b1;
        pend_addr = mem_req_addr;
        if (nlog < 8) log_addr[nlog] = mem_req_addr;
        nlog++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  // drive a low pulse and follow the wake sequence until awake
  task automatic wake_measure(input int low_cyc, output int lat, output int width,
                              output bit woke, output bit waking_seen);
    lat = -1; width = 0; woke = 1'b0; waking_seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      host_drv = (i < low_cyc) ? 1'b0 : 1'b1;
      if (st_waking) waking_seen = 1'b1;
      if (bus_pd_en) begin
        if (lat < 0) lat = i;
        width++;
      end
      if (st_awake) begin
        woke = 1'b1;
        break;
      end
    end
  endtask

  // count awake samples since the last bus_rx change until sleep
  task automatic sleep_wait(input int run0, output int run);
    logic prev;
    run = run0;
    prev = bus_rx;
    for (int i = 0; i < 4 * IDLE; i++) begin
      @(negedge clk);
      if (st_asleep) return;
      if (bus_rx != prev) run = 1;
      else run++;
      prev = bus_rx;
    end
    run = -1;
  endtask

  task automatic t_reset();
    chk(st_asleep && !st_waking && !st_awake, "R1 state flags", st_asleep, 1);
    chk(!bus_pd_en && bus_rx, "R1 bus outputs", bus_pd_en, 0);
    chk(aslp_en, "R1 aslp_en", aslp_en, 1);
    chk(cfg_bytes == '0 && !mem_req_valid, "R1 cfg/mem", int'(cfg_bytes), 0);
    repeat (20) @(negedge clk);
    chk(st_asleep, "R3 rising edge does not wake", st_asleep, 1);
  endtask

  task automatic t_glitch_reject();
    bit pd_seen = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      host_drv = (i < DG - 1) ? 1'b0 : 1'b1;
      if (bus_pd_en || !st_asleep) pd_seen = 1'b1;
    end
    chk(!pd_seen && st_asleep, "R2 sub-filter pulse ignored in sleep", pd_seen, 0);
  endtask

  task automatic t_wake_short();
    int lat, width, run;
    bit woke, ws;
    nlog = 0;
    wake_measure(DG + 1, lat, width, woke, ws);
    chk(woke, "R6 awake after short break", woke, 1);
    chk(ws, "R4 waking flag seen", ws, 1);
    chk(lat >= DG + PW + 2 && lat <= DG + PW + 4 * NCFG + 12, "R4 wake latency", lat, DG + PW + 6);
    chk(width == READY_EXP, "R6 ready width", width, READY_EXP);
    chk(nlog == NCFG, "R5 request count", nlog, NCFG);
    for (int b = 0; b < NCFG; b++) begin
      chk(log_addr[b] == AW'(BASE + b), "R5 address order", int'(log_addr[b]), BASE + b);
      chk(cfg_bytes[8*b +: 8] == mem_val(AW'(BASE + b)), "R5 cfg byte",
          int'(cfg_bytes[8*b +: 8]), int'(mem_val(AW'(BASE + b))));
    end
    sleep_wait(1, run);
    chk(run >= IDLE && run <= IDLE + 1, "R8 timeout idle high", run, IDLE + 1);
  endtask

  task automatic t_awake_traffic();
    int lat, width, run;
    bit woke, ws, saw_low, bad;
    wake_measure(DG + 1, lat, width, woke, ws);
    chk(woke, "R7 setup wake", woke, 1);
    repeat (10) @(negedge clk);
    // sub-filter pulse while awake
    saw_low = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      host_drv = (i < DG - 1) ? 1'b0 : 1'b1;
      if (!bus_rx) saw_low = 1'b1;
    end
    chk(!saw_low, "R2 sub-filter pulse hidden from bus_rx", saw_low, 0);
    // traffic pulse longer than filter
    saw_low = 1'b0; bad = 1'b0;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      host_drv = (i < DG + 2) ? 1'b0 : 1'b1;
      if (!bus_rx) saw_low = 1'b1;
      if (bus_pd_en || !st_awake) bad = 1'b1;
    end
    chk(saw_low, "R7 traffic pulse on bus_rx", saw_low, 1);
    chk(!bad, "R7 traffic does not rewake", bad, 0);
    sleep_wait(1, run);
    chk(run >= IDLE && run <= IDLE + 1, "R8 restart by edge", run, IDLE + 1);
  endtask

  task automatic t_merge_and_low_sleep();
    int lat, width, run;
    bit woke, ws, bad;
    wake_measure(200, lat, width, woke, ws);
    chk(woke, "R6 awake with merged break", woke, 1);
    chk(width == READY_EXP, "R6 ready width when merged", width, READY_EXP);
    chk(host_drv == 1'b0, "R4 host still low at ready", int'(host_drv), 0);
    sleep_wait(1, run);
    chk(run == IDLE, "R8 timeout idle low", run, IDLE);
    bad = 1'b0;
    for (int i = 0; i < 3 * IDLE; i++) begin
      @(negedge clk);
      if (!st_asleep) bad = 1'b1;
    end
    chk(!bad, "R3 low bus does not rewake", bad, 0);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      host_drv = 1'b1;
      if (!st_asleep) bad = 1'b1;
    end
    chk(!bad, "R3 rise does not wake", bad, 0);
    wake_measure(DG + 1, lat, width, woke, ws);
    chk(woke, "R3 fall after rise wakes", woke, 1);
  endtask

  task automatic t_aslp_ctrl();
    int run;
    bit bad;
    @(negedge clk);
    aslp_wr_en = 1'b1; aslp_wr_val = 1'b0;
    @(negedge clk);
    aslp_wr_en = 1'b0;
    chk(!aslp_en, "R9 write clears enable", aslp_en, 0);
    bad = 1'b0;
    for (int i = 0; i < 3 * IDLE; i++) begin
      @(negedge clk);
      if (!st_awake) bad = 1'b1;
    end
    chk(!bad, "R9 no timeout when disabled", bad, 0);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk(aslp_en, "R9 soft reset sets enable", aslp_en, 1);
    sleep_wait(1, run);
    chk(run >= IDLE - 1 && run <= IDLE + 2, "R9 timeout after soft reset", run, IDLE);
    chk(st_asleep && bus_rx, "R7 bus_rx high when asleep", bus_rx, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_glitch_reject();
    t_wake_short();
    t_awake_traffic();
    t_merge_and_low_sleep();
    t_aslp_ctrl();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    vecs++;
    errs++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

endmodule